// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides when a step-down regulator's output may be reported as good and drives the pull-down of an open-drain power-good line. The feedback voltage is compared against four fixed levels by analog comparators outside the block. Their flags arrive here as digital inputs. The block adds hysteresis: a narrow inner window must be met before the output can become good, and a wider outer window must be left before good is lost.

Good can only be reported once soft-start has finished. After that, the voltage must stay inside the inner window for a fixed number of slow timebase ticks (about 1.25 ms). A good output is dropped only after the voltage has stayed outside the outer window for a second tick count (about 1.5 ms). Each count starts again from zero as soon as its condition breaks. A latched protection fault pulls the line low in the same cycle. So does removing enable. Removing enable also forgets that soft-start finished.

The four comparator levels are placed relative to the 0.8 V reference:
- inner window from 90 % to 120 %
- outer window from 85 % to 125 %

Top module: `pgw_monitor`

## Requirements
- R1: While reset is asserted or `enable` is low, `pgPullLow` is 1, and no tick count is kept.
- R2: While enabled, `pgPullLow` stays 1 until a one-cycle `ssDone` pulse has been seen. In-window ticks before that pulse do not count toward assertion.
- R3: After `ssDone`, `pgPullLow` goes to 0 after the clock edge that samples the ASSERT_TICKS-th `tick`. Every one of those ticks must be seen with the voltage in the inner window: `fbAboveHiIn`=0 and `fbBelowLoIn`=0.
- R4: While not good, any cycle in which the inner-window condition is false restarts the assertion count from zero. This includes a voltage in the 85–90 % or 120–125 % bands.
- R5: Once good, a voltage in the hysteresis bands keeps the output good indefinitely. In those bands `fbAboveHiIn` or `fbBelowLoIn` may be 1, while `fbAboveHiOut`=0 and `fbBelowLoOut`=0.
- R6: Once good, `pgPullLow` returns to 1 after the edge that samples the DEASSERT_TICKS-th tick with `fbAboveHiOut`=1 or `fbBelowLoOut`=1. Any cycle back inside the outer window restarts that count.
- R7: `faultLatched`=1 sets `pgPullLow` to 1 in the same cycle, with no clock edge needed. After the fault clears, a full fresh ASSERT_TICKS qualification is required, and no new soft-start pulse is needed.
- R8: Dropping `enable` sets `pgPullLow` to 1 in the same cycle. After `enable` returns, a new `ssDone` pulse is required before qualification starts.
- R9: Delays advance only on cycles where `tick`=1. Cycles without a tick neither advance nor restart a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; low forces not-good and clears history |
| ssDone | input | 1 | One-cycle pulse at the end of soft-start |
| faultLatched | input | 1 | Any latched protection fault (over/under-voltage, over-current, thermal) |
| tick | input | 1 | One-cycle pulse of the slow delay timebase |
| fbAboveHiIn | input | 1 | Feedback above the upper inner level (120 %) |
| fbAboveHiOut | input | 1 | Feedback above the upper outer level (125 %) |
| fbBelowLoIn | input | 1 | Feedback below the lower inner level (90 %) |
| fbBelowLoOut | input | 1 | Feedback below the lower outer level (85 %) |
| pgPullLow | output | 1 | 1 = pull the open-drain power-good line low (not good); 0 = release (good) |

## Verification
The bench targets these corners:
- **In-window voltage before soft-start.** A design that counts ticks early would report good as soon as the soft-start pulse arrives.
- **Qualification broken by a visit to the hysteresis band.** A design that pauses instead of restarting the count would assert early.
- **Good held while sitting in the bands.** A design without hysteresis would drop the output.
- **Short excursions past the outer levels, and long tickless gaps.** These catch a design that drops good too soon, or that counts clock cycles instead of ticks.
- **Faults and enable removal.** A design that gates these through a register would show one cycle of false good. A design that keeps stale counts would requalify too early.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_QUAL = 2'd1,
    ST_GOOD = 2'd2
  } pgwState_e;

  typedef struct packed {
    logic runAsrt;
    logic runDsrt;
    logic holdGood;
  } pgwStrobe_t;

endpackage

// File: rtl/pgw_tick_cnt.sv
module pgw_tick_cnt #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> cnt == '0); // R4
  AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> $stable(cnt)); // R9

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ASSERT_TICKS   = 5,
  parameter int DEASSERT_TICKS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       faultLatched,
  input  logic       tick,
  input  logic       fbAboveHiIn,
  input  logic       fbAboveHiOut,
  input  logic       fbBelowLoIn,
  input  logic       fbBelowLoOut,
  input  pgwStrobe_t strobe,
  output logic       innerOk,
  output logic       outerLost,
  output logic       asrtDone,
  output logic       dsrtDone,
  output logic       pgPullLow
);

  // Hysteretic window: tight levels to enter, wide levels to leave.
  assign innerOk   = !fbAboveHiIn && !fbBelowLoIn;
  assign outerLost = fbAboveHiOut || fbBelowLoOut;

  pgw_tick_cnt #(.LIMIT(ASSERT_TICKS)) uAsrtCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (strobe.runAsrt),
    .tick (tick),
    .done (asrtDone)
  );

  pgw_tick_cnt #(.LIMIT(DEASSERT_TICKS)) uDsrtCnt (
    .clk  (clk),
    .rstN (rstN),
    .run  (strobe.runDsrt),
    .tick (tick),
    .done (dsrtDone)
  );

  // Fault and enable act without a clock edge.
  assign pgPullLow = !(strobe.holdGood && enable && !faultLatched);

  AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.runAsrt && strobe.runDsrt)); // R6

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ssDone,
  input  logic       faultLatched,
  input  logic       innerOk,
  input  logic       outerLost,
  input  logic       asrtDone,
  input  logic       dsrtDone,
  output pgwStrobe_t strobe
);

  pgwState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (!enable) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  if (ssDone) stateNxt = ST_QUAL;
        ST_QUAL: if (!faultLatched && asrtDone) stateNxt = ST_GOOD;
        ST_GOOD: begin
          if (faultLatched)  stateNxt = ST_QUAL;
          else if (dsrtDone) stateNxt = ST_QUAL;
        end
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.runAsrt  = enable && !faultLatched && (state == ST_QUAL) && innerOk;
    strobe.runDsrt  = enable && !faultLatched && (state == ST_GOOD) && outerLost;
    strobe.holdGood = (state == ST_GOOD);
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == ST_OFF); // R8
  AST_NEED_SOFTSTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) |=> state != ST_GOOD); // R2
  AST_GOOD_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.holdGood) |-> $past(asrtDone)); // R3
  AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |=> state != ST_GOOD); // R7
  AST_DROP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(strobe.holdGood) && $past(enable) && !$past(faultLatched)) |-> $past(dsrtDone)); // R6
  AST_BAND_KEEPS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GOOD && enable && !faultLatched && !outerLost) |=> state == ST_GOOD); // R5

endmodule

// File: rtl/pgw_monitor.sv
module pgw_monitor
  import pgw_pkg::*;
#(
  parameter int ASSERT_TICKS   = 5,
  parameter int DEASSERT_TICKS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic ssDone,
  input  logic faultLatched,
  input  logic tick,
  input  logic fbAboveHiIn,
  input  logic fbAboveHiOut,
  input  logic fbBelowLoIn,
  input  logic fbBelowLoOut,
  output logic pgPullLow
);

  pgwStrobe_t strobe;
  logic innerOk, outerLost, asrtDone, dsrtDone;

  pgw_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .ssDone       (ssDone),
    .faultLatched (faultLatched),
    .innerOk      (innerOk),
    .outerLost    (outerLost),
    .asrtDone     (asrtDone),
    .dsrtDone     (dsrtDone),
    .strobe       (strobe)
  );

  pgw_datapath #(
    .ASSERT_TICKS   (ASSERT_TICKS),
    .DEASSERT_TICKS (DEASSERT_TICKS)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .faultLatched (faultLatched),
    .tick         (tick),
    .fbAboveHiIn  (fbAboveHiIn),
    .fbAboveHiOut (fbAboveHiOut),
    .fbBelowLoIn  (fbBelowLoIn),
    .fbBelowLoOut (fbBelowLoOut),
    .strobe       (strobe),
    .innerOk      (innerOk),
    .outerLost    (outerLost),
    .asrtDone     (asrtDone),
    .dsrtDone     (dsrtDone),
    .pgPullLow    (pgPullLow)
  );

endmodule

// File: tb/sim_pgw_monitor.sv
module sim_pgw_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int A_TICKS = 5;
  localparam int D_TICKS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, ssDone = 1'b0, faultLatched = 1'b0, tick = 1'b0;
  logic fbAboveHiIn = 1'b0, fbAboveHiOut = 1'b0, fbBelowLoIn = 1'b0, fbBelowLoOut = 1'b0;
  logic pgPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_monitor #(.ASSERT_TICKS(A_TICKS), .DEASSERT_TICKS(D_TICKS)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .ssDone(ssDone),
    .faultLatched(faultLatched), .tick(tick),
    .fbAboveHiIn(fbAboveHiIn), .fbAboveHiOut(fbAboveHiOut),
    .fbBelowLoIn(fbBelowLoIn), .fbBelowLoOut(fbBelowLoOut),
    .pgPullLow(pgPullLow)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  bit mGood = 0, mSeen = 0;
  int mCnt = 0;

  // Voltage level: 0 <85%, 1 85-90%, 2 90-120%, 3 120-125%, 4 >125%
  task automatic cyc(input bit en, input bit ss, input bit flt, input bit tk,
                     input int lvl, input string tag);
    item_t it;
    @(negedge clk);
    enable = en; ssDone = ss; faultLatched = flt; tick = tk;
    fbBelowLoOut = (lvl == 0);
    fbBelowLoIn  = (lvl <= 1);
    fbAboveHiIn  = (lvl >= 3);
    fbAboveHiOut = (lvl == 4);
    if (!en) begin
      mGood = 0; mSeen = 0; mCnt = 0;
    end else if (!mSeen) begin
      mSeen = ss; mCnt = 0;
    end else if (flt) begin
      mGood = 0; mCnt = 0;
    end else if (!mGood) begin
      if (lvl == 2) begin
        if (tk) begin
          if (mCnt == A_TICKS-1) begin mGood = 1; mCnt = 0; end
          else mCnt++;
        end
      end else mCnt = 0;
    end else begin
      if (lvl == 0 || lvl == 4) begin
        if (tk) begin
          if (mCnt == D_TICKS-1) begin mGood = 0; mCnt = 0; end
          else mCnt++;
        end
      end else mCnt = 0;
    end
    it.exp = !(mGood && en && !flt);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic run(input int n, input bit en, input bit flt, input int lvl,
                     input int every, input string tag);
    for (int i = 0; i < n; i++)
      cyc(en, 1'b0, flt, (every > 0) && (i % every == every-1), lvl, tag);
  endtask

  // Monitor: compare against the scoreboard away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (pgPullLow !== it.exp) begin
          fails++;
          $display("FAIL %s: pgPullLow actual=%0b expected=%0b at %0t",
                   it.tag, pgPullLow, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pgPullLow !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: actual=%0b expected=1", pgPullLow);
    end
    rstN = 1'b1;

    run(10, 0, 0, 2, 2, "R1 disabled");
    run(20, 1, 0, 2, 2, "R2 before soft-start");
    cyc(1, 1, 0, 0, 2, "R2 ss pulse");
    run(20, 1, 0, 2, 3, "R3 qualify");
    run(20, 1, 0, 1, 2, "R5 low band");
    run(20, 1, 0, 3, 2, "R5 high band");
    run(12, 1, 0, 4, 3, "R6 short over");
    run(3,  1, 0, 2, 1, "R6 restart");
    run(40, 1, 0, 4, 0, "R9 no ticks");
    run(30, 1, 0, 0, 3, "R6 under drop");
    run(9,  1, 0, 2, 3, "R4 partial");
    run(4,  1, 0, 3, 2, "R4 high band break");
    run(9,  1, 0, 2, 3, "R4 partial again");
    run(2,  1, 0, 1, 1, "R4 low band break");
    run(30, 1, 0, 2, 3, "R4 full qualify");
    run(10, 1, 1, 2, 2, "R7 fault");
    run(20, 1, 0, 2, 2, "R7 requalify");
    run(6,  0, 0, 2, 2, "R8 disable");
    run(20, 1, 0, 2, 2, "R8 need new ss");
    cyc(1, 1, 0, 1, 2, "R8 ss pulse");
    run(12, 1, 0, 2, 1, "R8 qualify");
    run(14, 1, 0, 4, 1, "R6 over drop");
    cyc(1, 1, 1, 0, 2, "R7 fault single");
    run(5,  1, 0, 2, 0, "R9 idle");
    run(3,  0, 0, 2, 1, "R1 disabled end");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule